// File: doc/BRIEF.md
# Exception entry sequencer

This block performs the register-side work of entering an exception on a processor core that keeps a banked register file. Each cycle it samples an interrupt request, a prefetch-abort strobe and a data-abort strobe, together with the live status word and program counter of the core. When a request is accepted, the next cycle carries four things at once: the new status word, the saved copy of the old status word for the bank of the target mode, the link value, and a one-cycle redirect pulse with the vector address for instruction fetch.

A strap input chooses between a high exception base (0xFFFF0000) and a low one (0x00000000). The vector offset, the link adjustment and the status rewrite all depend on the exception taken. The link adjustment also depends on whether the interrupted code ran in the compressed instruction set (status bit 5).

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, redir_o, stat_we_o, saved_we_o and link_we_o are low and all data outputs are zero.
- R2: An interrupt request that arrives while status bit 7 (interrupt mask) is set, with no abort strobe, produces no redirect and no register write.
- R3: On interrupt entry the new status keeps bits 31:8 and sets bits 7:0 to 0xD2: mode field bits 4:0 = 0x12, both masks (bits 7 and 6) set, compressed bit 5 cleared.
- R4: On either abort, the new status keeps bits 31:8 and bit 6, and sets bits 7:0 to (old[7:0] AND 0x40) OR 0x97: mode field 0x17, bit 7 set, bit 5 cleared.
- R5: The saved status output carries the status word sampled with the request, and saved_mode_o names the target bank (0x12 for interrupt, 0x17 for either abort).
- R6: For interrupt and prefetch abort, the link value is the sampled program counter plus 2 when old bit 5 was set, plus 0 otherwise.
- R7: For data abort, the link value is the sampled program counter plus 6 when old bit 5 was set, plus 4 otherwise.
- R8: The redirect address is the exception base plus 0x18 for interrupt, 0x0C for prefetch abort and 0x10 for data abort.
- R9: The exception base is 0xFFFF0000 when base_hi_i is high and 0x00000000 when it is low.
- R10: When several requests are present in one cycle, data abort wins over prefetch abort, which wins over interrupt; aborts are taken even while status bit 7 is set.
- R11: An accepted request raises redir_o and all three write strobes together in the next cycle, for exactly one cycle per sampled request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | Interrupt request |
| pabt_i | input | 1 | Prefetch-abort strobe |
| dabt_i | input | 1 | Data-abort strobe |
| base_hi_i | input | 1 | Strap: high exception base when set |
| stat_i | input | 32 | Live status word |
| pc_i | input | 32 | Live program counter |
| stat_we_o | output | 1 | Write strobe for the status word |
| stat_o | output | 32 | New status word |
| saved_we_o | output | 1 | Write strobe for the banked saved status |
| saved_mode_o | output | 5 | Mode whose saved-status bank is written |
| saved_o | output | 32 | Status word before entry |
| link_we_o | output | 1 | Write strobe for the banked link register |
| link_o | output | 32 | Link value |
| redir_o | output | 1 | One-cycle fetch redirect pulse |
| redir_addr_o | output | 32 | Vector address for the redirect |

## Verification
The assertions take for granted that the core holds stat_i and pc_i steady while a request is sampled and that base_hi_i is a static strap; the saved-status check compares against the status of the previous cycle and so relies on that. They also assume the mode field of stat_i holds a legal mode value and that strobes are single-cycle events. The stimulus drives every request for exactly one cycle at the falling edge, sets the strap before the request, and returns all strobes to low between vectors so that each entry is checked in isolation.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_IRQ  = 2'd1,
    EXC_PABT = 2'd2,
    EXC_DABT = 2'd3
  } exc_kind_e;

  localparam int          MODE_W    = 5;
  localparam logic [4:0]  MODE_IRQ  = 5'h12;
  localparam logic [4:0]  MODE_ABT  = 5'h17;
  localparam int          IMASK_BIT = 7;
  localparam int          FMASK_BIT = 6;
  localparam int          CMP_BIT   = 5;
  localparam logic [7:0]  IRQ_LOW   = 8'hD2;
  localparam logic [7:0]  ABT_SET   = 8'h97;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      irq_i,
  input  logic      pabt_i,
  input  logic      dabt_i,
  input  logic      imask_i,
  output exc_kind_e kind_o
);
  always_comb begin
    if (dabt_i)                 kind_o = EXC_DABT;
    else if (pabt_i)            kind_o = EXC_PABT;
    else if (irq_i && !imask_i) kind_o = EXC_IRQ;
    else                        kind_o = EXC_NONE;
  end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] HI_BASE  = 32'hFFFF_0000,
  parameter logic [7:0]  IRQ_OFS  = 8'h18,
  parameter logic [7:0]  PABT_OFS = 8'h0C,
  parameter logic [7:0]  DABT_OFS = 8'h10
) (
  input  exc_kind_e         kind_i,
  input  logic [XLEN-1:0]   stat_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              base_hi_i,
  output logic [XLEN-1:0]   stat_o,
  output logic [XLEN-1:0]   link_o,
  output logic [XLEN-1:0]   vec_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam logic [XLEN-1:0] BASE_HI = XLEN'(HI_BASE);

  logic            cmp;
  logic [7:0]      low_new;
  logic [7:0]      ofs;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] adj;

  assign cmp  = stat_i[CMP_BIT];
  assign base = base_hi_i ? BASE_HI : '0;

  always_comb begin
    low_new = stat_i[7:0];
    ofs     = '0;
    mode_o  = stat_i[MODE_W-1:0];
    adj     = '0;
    unique case (kind_i)
      EXC_IRQ: begin
        low_new = IRQ_LOW;
        ofs     = IRQ_OFS;
        mode_o  = MODE_IRQ;
        adj     = cmp ? XLEN'(2) : XLEN'(0);
      end
      EXC_PABT: begin
        low_new = (stat_i[7:0] & (8'h1 << FMASK_BIT)) | ABT_SET;
        ofs     = PABT_OFS;
        mode_o  = MODE_ABT;
        adj     = cmp ? XLEN'(2) : XLEN'(0);
      end
      EXC_DABT: begin
        low_new = (stat_i[7:0] & (8'h1 << FMASK_BIT)) | ABT_SET;
        ofs     = DABT_OFS;
        mode_o  = MODE_ABT;
        adj     = cmp ? XLEN'(6) : XLEN'(4);
      end
      default: ;
    endcase
  end

  assign stat_o = {stat_i[XLEN-1:8], low_new};
  assign link_o = pc_i + adj;
  assign vec_o  = base + XLEN'(ofs);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              pabt_i,
  input  logic              dabt_i,
  input  logic              base_hi_i,
  input  logic [XLEN-1:0]   stat_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic              stat_we_o,
  output logic [XLEN-1:0]   stat_o,
  output logic              saved_we_o,
  output logic [MODE_W-1:0] saved_mode_o,
  output logic [XLEN-1:0]   saved_o,
  output logic              link_we_o,
  output logic [XLEN-1:0]   link_o,
  output logic              redir_o,
  output logic [XLEN-1:0]   redir_addr_o
);
  exc_kind_e         kind;
  logic [XLEN-1:0]   stat_d, link_d, vec_d;
  logic [MODE_W-1:0] mode_d;

  logic              take_q;
  logic [XLEN-1:0]   stat_q, saved_q, link_q, vec_q;
  logic [MODE_W-1:0] mode_q;

  exc_arbiter u_arb (
    .irq_i   (irq_i),
    .pabt_i  (pabt_i),
    .dabt_i  (dabt_i),
    .imask_i (stat_i[IMASK_BIT]),
    .kind_o  (kind)
  );

  exc_frame #(.XLEN(XLEN), .HI_BASE(HI_BASE)) u_frame (
    .kind_i    (kind),
    .stat_i    (stat_i),
    .pc_i      (pc_i),
    .base_hi_i (base_hi_i),
    .stat_o    (stat_d),
    .link_o    (link_d),
    .vec_o     (vec_d),
    .mode_o    (mode_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q  <= 1'b0;
      stat_q  <= '0;
      saved_q <= '0;
      link_q  <= '0;
      vec_q   <= '0;
      mode_q  <= '0;
    end else if (kind != EXC_NONE) begin
      take_q  <= 1'b1;
      stat_q  <= stat_d;
      saved_q <= stat_i;
      link_q  <= link_d;
      vec_q   <= vec_d;
      mode_q  <= mode_d;
    end else begin
      take_q  <= 1'b0;
    end
  end

  assign stat_we_o    = take_q;
  assign saved_we_o   = take_q;
  assign link_we_o    = take_q;
  assign redir_o      = take_q;
  assign stat_o       = stat_q;
  assign saved_o      = saved_q;
  assign saved_mode_o = mode_q;
  assign link_o       = link_q;
  assign redir_addr_o = vec_q;

  a_r2_masked_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && stat_i[IMASK_BIT] && !pabt_i && !dabt_i) |=> !redir_o);

  a_r3_irq_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_o && saved_mode_o == MODE_IRQ) |->
      (stat_o[7:6] == 2'b11 && !stat_o[CMP_BIT] && stat_o[4:0] == MODE_IRQ));

  a_r4_abort_fmask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_o && saved_mode_o == MODE_ABT) |->
      (stat_o[FMASK_BIT] == saved_o[FMASK_BIT] && stat_o[IMASK_BIT]
       && stat_o[4:0] == MODE_ABT));

  a_r5_saved_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> saved_o == $past(stat_i));

  a_r10_dabt_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dabt_i |=> (redir_o && redir_addr_o[7:0] == 8'h10));

  a_r11_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> (stat_we_o && saved_we_o && link_we_o));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0, pabt_i = 1'b0, dabt_i = 1'b0, base_hi_i = 1'b0;
  logic [31:0] stat_i = '0, pc_i = '0;
  logic        stat_we_o, saved_we_o, link_we_o, redir_o;
  logic [31:0] stat_o, saved_o, link_o, redir_addr_o;
  logic [4:0]  saved_mode_o;

  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  exc_entry_seq u_exc_entry_seq (.*);

  typedef struct packed {
    logic        irq, pabt, dabt, hi;
    logic [31:0] stat, pc;
    logic        take;
    logic [31:0] xstat, xlink, xvec;
    logic [4:0]  xmode;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0, 32'h0000001F, 32'h02000100, 1'b1, 32'h000000D2, 32'h02000100, 32'h00000018, 5'h12},
    '{1'b1,1'b0,1'b0,1'b1, 32'h6000003F, 32'h02000202, 1'b1, 32'h600000D2, 32'h02000204, 32'hFFFF0018, 5'h12},
    '{1'b1,1'b0,1'b0,1'b0, 32'h0000009F, 32'h02000300, 1'b0, 32'h0,        32'h0,        32'h0,        5'h00},
    '{1'b0,1'b1,1'b0,1'b1, 32'h0000005F, 32'h00001000, 1'b1, 32'h000000D7, 32'h00001000, 32'hFFFF000C, 5'h17},
    '{1'b0,1'b1,1'b0,1'b0, 32'h80000030, 32'h00003000, 1'b1, 32'h80000097, 32'h00003002, 32'h0000000C, 5'h17},
    '{1'b0,1'b0,1'b1,1'b0, 32'h00000010, 32'h00004000, 1'b1, 32'h00000097, 32'h00004004, 32'h00000010, 5'h17},
    '{1'b0,1'b0,1'b1,1'b1, 32'h000000F2, 32'h00005000, 1'b1, 32'h000000D7, 32'h00005006, 32'hFFFF0010, 5'h17},
    '{1'b1,1'b1,1'b1,1'b0, 32'h0000001F, 32'h00006000, 1'b1, 32'h00000097, 32'h00006004, 32'h00000010, 5'h17},
    '{1'b1,1'b1,1'b0,1'b0, 32'h0000001F, 32'h00007000, 1'b1, 32'h00000097, 32'h00007000, 32'h0000000C, 5'h17},
    '{1'b1,1'b0,1'b1,1'b0, 32'h0000009F, 32'h00008000, 1'b1, 32'h00000097, 32'h00008004, 32'h00000010, 5'h17},
    '{1'b0,1'b0,1'b0,1'b1, 32'h0000001F, 32'h00009000, 1'b0, 32'h0,        32'h0,        32'h0,        5'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " redir"}, 32'(redir_o), 32'd0);
    chk({tag, " strobes"}, {29'd0, stat_we_o, saved_we_o, link_we_o}, 32'd0);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    irq_i = 1'b1; pabt_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    check_idle("R1 in reset");
    chk("R1 stat", stat_o, 32'd0);
    chk("R1 link", link_o, 32'd0);
    chk("R1 vector", redir_addr_o, 32'd0);
    @(negedge clk_i);
    irq_i = 1'b0; pabt_i = 1'b0;
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_idle("R1 after release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      irq_i = TBL[i].irq; pabt_i = TBL[i].pabt; dabt_i = TBL[i].dabt;
      base_hi_i = TBL[i].hi; stat_i = TBL[i].stat; pc_i = TBL[i].pc;
      @(posedge clk_i); #1;
      if (TBL[i].take) begin
        chk("R11 redir", 32'(redir_o), 32'd1);
        chk("R11 strobes", {29'd0, stat_we_o, saved_we_o, link_we_o}, 32'd7);
        chk("R3 R4 R10 status", stat_o, TBL[i].xstat);
        chk("R5 saved", saved_o, TBL[i].stat);
        chk("R5 saved mode", 32'(saved_mode_o), 32'(TBL[i].xmode));
        chk("R6 R7 R10 link", link_o, TBL[i].xlink);
        chk("R8 R9 R10 vector", redir_addr_o, TBL[i].xvec);
      end else begin
        check_idle("R2 no entry");
      end
      @(negedge clk_i);
      irq_i = 1'b0; pabt_i = 1'b0; dabt_i = 1'b0;
      @(posedge clk_i); #1;
      check_idle("R11 single pulse");
    end

    // R1: reset asserted while an entry is pending
    @(negedge clk_i);
    dabt_i = 1'b1; stat_i = 32'h1F; pc_i = 32'hA000;
    @(posedge clk_i); #1;
    chk("R11 redir before reset", 32'(redir_o), 32'd1);
    rst_ni = 1'b0; #1;
    check_idle("R1 async reset");
    chk("R1 link cleared", link_o, 32'd0);
    @(negedge clk_i);
    dabt_i = 1'b0; rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule